// File: doc/BRIEF.md
# Outbound Address Translation Windows

This block rewrites requester addresses on their way from an AXI-side master toward a PCIe request path. Each request address first has a fixed AXI offset removed, which yields an internal address. The internal address is then checked against a small set of programmable outbound windows. Every window has the same size: a power-of-two number of mebibytes, set by a parameter. When a valid window holds the address, the window's base is replaced by that window's programmed 64-bit PCIe base. The offset inside the window is carried through unchanged.

Software programs four 32-bit registers per window: a base pair and a target pair. The low base word also carries two flags, an enable and a size-configuration flag. The translation result is reported one cycle after the request is sampled, in one of three forms:
- a hit, with the window index and the PCIe address;
- a miss, when no valid window holds the address;
- an underflow error, when the request address lies below the AXI offset.

Top module: `ob_xlate`

## Requirements
- R1: After reset every window is disabled and every window register reads as 0, so any request in range of the offset yields a miss; `rsp_valid` is 0 after reset.
- R2: Window w (0 or 1) has four registers:
  - base low word at 0xD20+8w and base high word at 0xD24+8w;
  - target low word at 0xD40+8w and target high word at 0xD44+8w.
  A write updates the full 32 bits. A read pulse on `reg_rd` returns the register on `reg_rdata` in the following cycle. Any other address reads 0 and ignores writes.
- R3: The internal address is the request address minus AXI_OFFSET. A request below AXI_OFFSET raises `rsp_below_ofs`, with no hit and a zero output address.
- R4: Bit 0 of a base low word enables the window. A window with bit 0 clear never hits, even when its base would match.
- R5: Bit 1 of a base low word is a size-configuration flag. It is stored and read back, but it does not change matching. Base bits below the window alignment (20+WIN_MIB_LOG2 bits, including both flags) are ignored when comparing.
- R6: A window hits when the internal address, with the low 20+WIN_MIB_LOG2 bits dropped, equals its 64-bit base with the same bits dropped. On a hit:
  - `rsp_hit` is 1 and `rsp_win` gives the window index;
  - `rsp_pci_addr` is the target base with its low alignment bits cleared, plus the in-window offset.
- R7: When both windows hit, window 0 is reported.
- R8: A request that is not below the offset and hits no enabled window raises `rsp_miss`; `rsp_pci_addr` and `rsp_win` are 0. For every response exactly one of hit, miss and underflow is set.
- R9: A request sampled on a clock edge is answered in the following cycle with a single-cycle `rsp_valid`. Requests on consecutive edges give responses on consecutive cycles. A register write affects requests sampled on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| req_valid | input | 1 | Request present |
| req_axi_addr | input | AXI_AW (40) | Request address on the AXI side |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Address translated |
| rsp_miss | output | 1 | No enabled window holds the address |
| rsp_below_ofs | output | 1 | Request address below the AXI offset |
| rsp_win | output | WIN_IW (1) | Index of the hitting window |
| rsp_pci_addr | output | 64 | Translated PCIe address, 0 unless hit |

## Verification
The address sweep places requests at several points of each window:
- The first byte, a middle byte and the last byte of window 0 show that the in-window offset survives the rewrite.
- The first byte of window 1 distinguishes the two windows at their shared boundary.
- The byte just past the span, and an address at the top of the space, separate a miss from a hit.
- An address one below the offset and address zero separate the underflow error from an ordinary miss.

Directed patterns cover the rest:
- Overlapping windows show the priority order.
- Disabling a window shows that it can no longer hit.
- Bases written with flag bits and unaligned low bits show that those bits stay out of the compare.
- A base with nonzero high words shows that the upper 32 bits take part in the compare.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;
  localparam int REG_AW     = 12;
  localparam int WIN_STRIDE = 8;
  localparam int MIB_SHIFT  = 20;
  localparam int EN_BIT     = 0;
  localparam int SZ_BIT     = 1;

  localparam logic [REG_AW-1:0] BASE_LO_ADDR = 12'hD20;
  localparam logic [REG_AW-1:0] BASE_HI_ADDR = 12'hD24;
  localparam logic [REG_AW-1:0] TGT_LO_ADDR  = 12'hD40;
  localparam logic [REG_AW-1:0] TGT_HI_ADDR  = 12'hD44;

  typedef struct packed {
    logic [31:0] hi;
    logic [31:0] lo;
  } word_pair_t;

  function automatic logic [REG_AW-1:0] win_reg(input logic [REG_AW-1:0] first, input int w);
    return first + REG_AW'(w * WIN_STRIDE);
  endfunction
endpackage

// File: rtl/ob_xlate_regs.sv
module ob_xlate_regs
  import ob_xlate_pkg::*;
#(
  parameter int NUM_WIN = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [REG_AW-1:0]        addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output word_pair_t [NUM_WIN-1:0] base,
  output word_pair_t [NUM_WIN-1:0] tgt
);
  logic [31:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      tgt  <= '0;
    end else if (wr) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (addr == win_reg(BASE_LO_ADDR, w)) base[w].lo <= wdata;
        if (addr == win_reg(BASE_HI_ADDR, w)) base[w].hi <= wdata;
        if (addr == win_reg(TGT_LO_ADDR, w))  tgt[w].lo  <= wdata;
        if (addr == win_reg(TGT_HI_ADDR, w))  tgt[w].hi  <= wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (addr == win_reg(BASE_LO_ADDR, w)) rd_mux = base[w].lo;
      if (addr == win_reg(BASE_HI_ADDR, w)) rd_mux = base[w].hi;
      if (addr == win_reg(TGT_LO_ADDR, w))  rd_mux = tgt[w].lo;
      if (addr == win_reg(TGT_HI_ADDR, w))  rd_mux = tgt[w].hi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/ob_xlate_match.sv
module ob_xlate_match
  import ob_xlate_pkg::*;
#(
  parameter int NUM_WIN   = 2,
  parameter int WIN_SHIFT = 27,
  parameter int WIN_IW    = 1
) (
  input  logic [63:0]              int_addr,
  input  word_pair_t [NUM_WIN-1:0] base,
  input  word_pair_t [NUM_WIN-1:0] tgt,
  output logic                     hit,
  output logic [WIN_IW-1:0]        win,
  output logic [63:0]              pci
);
  logic [NUM_WIN-1:0]        in_win;
  logic [NUM_WIN-1:0][63:0]  pci_w;
  logic [NUM_WIN-1:0]        unused_low;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [63:0] rbase;
    logic [63:0] tbase;
    assign rbase     = {base[w].hi, base[w].lo};
    assign tbase     = {tgt[w].hi, tgt[w].lo};
    assign in_win[w] = base[w].lo[EN_BIT] &&
                       (int_addr[63:WIN_SHIFT] == rbase[63:WIN_SHIFT]);
    assign pci_w[w]  = {tbase[63:WIN_SHIFT], int_addr[WIN_SHIFT-1:0]};
    assign unused_low[w] = ^{rbase[WIN_SHIFT-1:0], tbase[WIN_SHIFT-1:0]};
  end

  // lowest index wins: scan downward so the last assignment is window 0
  always_comb begin
    hit = 1'b0;
    win = '0;
    pci = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (in_win[i]) begin
        hit = 1'b1;
        win = WIN_IW'(i);
        pci = pci_w[i];
      end
    end
  end
endmodule

// File: rtl/ob_xlate.sv
module ob_xlate
  import ob_xlate_pkg::*;
#(
  parameter int                AXI_AW       = 40,
  parameter logic [AXI_AW-1:0] AXI_OFFSET   = AXI_AW'(64'h4000_0000),
  parameter int                WIN_MIB_LOG2 = 7,
  parameter int                NUM_WIN      = 2,
  localparam int               WIN_SHIFT    = MIB_SHIFT + WIN_MIB_LOG2,
  localparam int               WIN_IW       = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [AXI_AW-1:0] req_axi_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_below_ofs,
  output logic [WIN_IW-1:0] rsp_win,
  output logic [63:0]       rsp_pci_addr
);
  word_pair_t [NUM_WIN-1:0] base;
  word_pair_t [NUM_WIN-1:0] tgt;

  logic              req_q;
  logic [AXI_AW-1:0] addr_q;
  logic              below;
  logic [63:0]       int_addr;
  logic              m_hit;
  logic [WIN_IW-1:0] m_win;
  logic [63:0]       m_pci;

  ob_xlate_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .rd    (reg_rd),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .base  (base),
    .tgt   (tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q <= req_valid;
      if (req_valid) addr_q <= req_axi_addr;
    end
  end

  assign below    = addr_q < AXI_OFFSET;
  assign int_addr = 64'(addr_q - AXI_OFFSET);

  ob_xlate_match #(
    .NUM_WIN   (NUM_WIN),
    .WIN_SHIFT (WIN_SHIFT),
    .WIN_IW    (WIN_IW)
  ) u_match (
    .int_addr (int_addr),
    .base     (base),
    .tgt      (tgt),
    .hit      (m_hit),
    .win      (m_win),
    .pci      (m_pci)
  );

  assign rsp_valid     = req_q;
  assign rsp_below_ofs = req_q & below;
  assign rsp_hit       = req_q & ~below & m_hit;
  assign rsp_miss      = req_q & ~below & ~m_hit;
  assign rsp_win       = rsp_hit ? m_win : '0;
  assign rsp_pci_addr  = rsp_hit ? m_pci : '0;
endmodule

// File: rtl/ob_xlate_chk.sv
module ob_xlate_chk #(
  parameter int                AXI_AW       = 40,
  parameter logic [AXI_AW-1:0] AXI_OFFSET   = AXI_AW'(64'h4000_0000),
  parameter int                WIN_MIB_LOG2 = 7,
  parameter int                NUM_WIN      = 2,
  localparam int               WIN_SHIFT    = 20 + WIN_MIB_LOG2,
  localparam int               WIN_IW       = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [AXI_AW-1:0] req_axi_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              rsp_below_ofs,
  input logic [WIN_IW-1:0] rsp_win,
  input logic [63:0]       rsp_pci_addr
);
  logic                 ready_q;
  logic                 req_below;
  logic [WIN_SHIFT-1:0] req_off;

  always_ff @(posedge clk) ready_q <= !rst;

  assign req_below = req_axi_addr < AXI_OFFSET;
  assign req_off   = WIN_SHIFT'(req_axi_addr - AXI_OFFSET);

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> (rsp_valid == $past(req_valid)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_below_ofs));

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_below_ofs}) == 1));

  assert_no_addr_on_err_R8: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_pci_addr == 64'd0 && rsp_win == '0));

  assert_below_ofs_R3: assert property (@(posedge clk) disable iff (rst)
    (ready_q && rsp_valid) |-> (rsp_below_ofs == $past(req_below)));

  assert_offset_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (ready_q && rsp_hit) |-> (rsp_pci_addr[WIN_SHIFT-1:0] == $past(req_off)));
endmodule

bind ob_xlate ob_xlate_chk #(
  .AXI_AW       (AXI_AW),
  .AXI_OFFSET   (AXI_OFFSET),
  .WIN_MIB_LOG2 (WIN_MIB_LOG2),
  .NUM_WIN      (NUM_WIN)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_axi_addr  (req_axi_addr),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_miss      (rsp_miss),
  .rsp_below_ofs (rsp_below_ofs),
  .rsp_win       (rsp_win),
  .rsp_pci_addr  (rsp_pci_addr)
);

// File: tb/ob_xlate_test.sv
`timescale 1ns/1ps
module ob_xlate_test;
  localparam logic [2:0] K_HIT = 3'b100, K_MISS = 3'b010, K_BELOW = 3'b001;

  typedef struct packed {
    logic [39:0] addr;
    logic [2:0]  kind;
    logic        win;
    logic [63:0] pci;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{40'h00_4000_0000, K_HIT,   1'b0, 64'h1_0000_0000},
    '{40'h00_4000_1234, K_HIT,   1'b0, 64'h1_0000_1234},
    '{40'h00_47FF_FFFF, K_HIT,   1'b0, 64'h1_07FF_FFFF},
    '{40'h00_4800_0000, K_HIT,   1'b1, 64'h1_0800_0000},
    '{40'h00_4FFF_FFFC, K_HIT,   1'b1, 64'h1_0FFF_FFFC},
    '{40'h00_5000_0000, K_MISS,  1'b0, 64'h0},
    '{40'h00_3FFF_FFFF, K_BELOW, 1'b0, 64'h0},
    '{40'h00_0000_0000, K_BELOW, 1'b0, 64'h0},
    '{40'hFF_FFFF_FFFF, K_MISS,  1'b0, 64'h0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [39:0] req_axi_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_below_ofs;
  logic [0:0]  rsp_win;
  logic [63:0] rsp_pci_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ob_xlate uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_axi_addr(req_axi_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_below_ofs(rsp_below_ofs), .rsp_win(rsp_win),
    .rsp_pci_addr(rsp_pci_addr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_rsp(input string tag, input logic [2:0] kind,
                           input logic win, input logic [63:0] pci);
    check({tag, " valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " kind"}, 64'({rsp_hit, rsp_miss, rsp_below_ofs}), 64'(kind));
    check({tag, " win"}, 64'(rsp_win), 64'(win));
    check({tag, " addr"}, rsp_pci_addr, pci);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic send(input string tag, input logic [39:0] a, input logic [2:0] kind,
                      input logic win, input logic [63:0] pci);
    @(negedge clk);
    req_valid = 1'b1; req_axi_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(tag, kind, win, pci);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    rd_check("R1 base lo w0 reset", 12'hD20, 32'h0);
    rd_check("R1 tgt hi w1 reset", 12'hD4C, 32'h0);
    send("R1 all windows disabled", 40'h00_4000_0000, K_MISS, 1'b0, 64'h0);

    // program two contiguous windows of 128 MiB
    wr(12'hD20, 32'h0000_0001); wr(12'hD24, 32'h0);
    wr(12'hD40, 32'h0000_0000); wr(12'hD44, 32'h1);
    wr(12'hD28, 32'h0800_0001); wr(12'hD2C, 32'h0);
    wr(12'hD48, 32'h0800_0000); wr(12'hD4C, 32'h1);
    rd_check("R2 base lo w1 readback", 12'hD28, 32'h0800_0001);
    rd_check("R2 tgt hi w0 readback", 12'hD44, 32'h1);

    // R6 R3 R8 R9: back-to-back sweep, one request per cycle
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0)
        check_rsp($sformatf("R6/R3/R8/R9 vector %0d", i - 1),
                  VECS[i-1].kind, VECS[i-1].win, VECS[i-1].pci);
      if (i < NV) begin
        req_valid = 1'b1; req_axi_addr = VECS[i].addr;
      end else begin
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R9 single-cycle response", 64'(rsp_valid), 64'd0);

    // R2: unmapped address
    wr(12'hD30, 32'hDEAD_BEEF);
    rd_check("R2 unmapped reads zero", 12'hD30, 32'h0);
    rd_check("R2 unmapped write ignored", 12'hD20, 32'h0000_0001);

    // R5: flag bit and unaligned low bits are not compared
    wr(12'hD20, 32'h0000_1003);
    rd_check("R5 size flag readback", 12'hD20, 32'h0000_1003);
    send("R5 flags ignored in compare", 40'h00_4000_0ABC, K_HIT, 1'b0, 64'h1_0000_0ABC);

    // R4: disabled window never hits
    wr(12'hD28, 32'h0800_0000);
    send("R4 disabled window 1", 40'h00_4800_0000, K_MISS, 1'b0, 64'h0);

    // R7: overlap, window 0 first
    wr(12'hD28, 32'h0000_0001);
    wr(12'hD4C, 32'h2);
    wr(12'hD48, 32'h0);
    send("R7 window 0 priority", 40'h00_4000_0100, K_HIT, 1'b0, 64'h1_0000_0100);
    wr(12'hD20, 32'h0000_0000);
    send("R4 window 0 disabled falls to 1", 40'h00_4000_0100, K_HIT, 1'b1, 64'h2_0000_0100);

    // R6: upper base word compared, target low bits masked
    wr(12'hD2C, 32'h1);
    wr(12'hD28, 32'h0800_0001);
    wr(12'hD4C, 32'h3);
    wr(12'hD48, 32'h1000_0FFF);
    send("R6 high base word", 40'h01_4800_0040, K_HIT, 1'b1, 64'h3_1000_0040);
    send("R6 high word mismatch", 40'h00_4800_0040, K_MISS, 1'b0, 64'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule